// File: doc/BRIEF.md
# Timebase Transfer Target Decoder

This block sits beside a chip's time-of-day unit and decides which core receives a time value when software asks for a transfer into that core's timebase. Software first writes a target word that names the destination. The word either carries a full register address, whose upper part picks a core by its base address, or a short core index. The block decodes the word at once and latches the result: a valid bit and a core index.

Software then writes a move command. The block accepts the command only when the time-of-day unit reports that it is running, the command's go bit is set, a valid target is latched and the chosen core is signalling that it is ready to receive. An accepted move raises that core's sent flag. The flag stays high until the core answers with a clear pulse. A target word that decodes to nothing, and any rejected move, produce a one-cycle error pulse.

Core base addresses, the mask of fitted cores and whether index mode is allowed are all parameters. Every output is registered, so each outcome appears one cycle after the write that caused it.

Top module: `tod_xfer_target`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tgt_valid` is 0, every `sent` bit is 0 and `err` is 0.
- R2: A write to offset 0x27 with data bit 28 set uses full-address mode, where the address is data[63:32]. The target is valid only when address[11:0] equals 0x4A3 and address[31:12] equals bits [31:12] of the base of a fitted core. If several cores match, the lowest index wins.
- R3: A write to offset 0x27 with data bit 28 clear uses index mode. The index is data[36:32] and data[37] is ignored. The target is valid only when index mode is enabled, the index is below NUM_CORES and that core is fitted.
- R4: A target write takes effect in the next cycle. A target write that decodes as invalid clears `tgt_valid` and raises `err` for exactly the next cycle.
- R5: A write to offset 0x17 is an accepted move only when `tod_running` is 1, data bit 63 is 1, a valid target is latched and `core_ready` of that core is 1. The move sets that core's `sent` bit in the next cycle.
- R6: A rejected move raises `err` for the next cycle and changes neither the `sent` flags nor the latched target.
- R7: A `sent` bit holds until its `core_clr` bit is pulsed, and it is low in the cycle after the clear. If a set and a clear reach the same core in the same cycle, the set wins.
- R8: A write to any other offset, or a cycle with no write, leaves the target unchanged and does not raise `err`.
- R9: At most one `sent` bit rises in any cycle, and only the bit of the latched target core can rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register offset of the write |
| wr_data | input | 64 | Write data |
| tod_running | input | 1 | Time-of-day unit is in its running state |
| core_ready | input | NUM_CORES | Per-core ready-to-receive |
| core_clr | input | NUM_CORES | Per-core acknowledge that clears the sent flag |
| tgt_valid | output | 1 | A valid target is latched |
| tgt_idx | output | 5 | Latched target core index |
| sent | output | NUM_CORES | Per-core sent-to-timebase flags |
| err | output | 1 | One-cycle pulse on an invalid target or a rejected move |

## Verification
A wrong decode shows up in the cycle after the target write, either as a wrong `tgt_idx` or `tgt_valid` or as a missing or extra `err`. A wrong latched target stays hidden until the next move, when the flag of the wrong core rises, or a move that should be accepted is rejected. Stale or stuck flag state is caught at the first clear or move that should change it, because the bench keeps its own model of all flags and compares the whole vector after every cycle.

// File: rtl/tod_xfer_pkg.sv
package tod_xfer_pkg;

    localparam int MAX_CORES = 32;
    localparam int IDX_W     = 5;
    localparam int OFS_W     = 6;

    localparam logic [OFS_W-1:0] OFS_TARGET = 6'h27;
    localparam logic [OFS_W-1:0] OFS_MOVE   = 6'h17;
    localparam logic [11:0]      TB_REG_NUM = 12'h4A3;

    localparam int MODE_BIT = 28;
    localparam int GO_BIT   = 63;
    localparam int ADDR_LO  = 32;

    typedef logic [MAX_CORES-1:0][31:0] base_tbl_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } target_t;

    typedef struct packed {
        target_t tgt;
        logic    err;
    } ctl_state_t;

    function automatic base_tbl_t default_bases();
        base_tbl_t tbl;
        for (int i = 0; i < MAX_CORES; i++) begin
            tbl[i] = 32'h2000_0000 + (32'(i) << 24);
        end
        return tbl;
    endfunction

endpackage

// File: rtl/tod_xfer_decode.sv
module tod_xfer_decode
    import tod_xfer_pkg::*;
#(
    parameter int          NUM_CORES    = 4,
    parameter base_tbl_t   CORE_BASE    = default_bases(),
    parameter logic [31:0] CORE_PRESENT = 32'h0000_000B,
    parameter bit          IDX_MODE_EN  = 1'b1
) (
    input  logic [31:0] addr_i,
    input  logic        full_mode_i,
    output target_t     tgt_o
);

    logic [NUM_CORES-1:0] base_hit;
    logic                 reg_ok;
    logic [IDX_W-1:0]     idx_field;
    target_t              full_tgt;
    target_t              index_tgt;

    assign reg_ok    = (addr_i[11:0] == TB_REG_NUM);
    assign idx_field = addr_i[IDX_W-1:0];

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_base_cmp
        assign base_hit[g] = CORE_PRESENT[g] && (CORE_BASE[g][31:12] == addr_i[31:12]);
    end

    always_comb begin
        full_tgt = '0;
        for (int g = NUM_CORES - 1; g >= 0; g--) begin
            if (base_hit[g]) begin
                full_tgt.valid = reg_ok;
                full_tgt.idx   = IDX_W'(g);
            end
        end
    end

    always_comb begin
        index_tgt.idx   = idx_field;
        index_tgt.valid = IDX_MODE_EN && (int'(idx_field) < NUM_CORES) && CORE_PRESENT[idx_field];
    end

    assign tgt_o = full_mode_i ? full_tgt : index_tgt;

    always_comb begin
        if (tgt_o.valid) begin
            AST_DEC_FITTED: assert (CORE_PRESENT[tgt_o.idx] && int'(tgt_o.idx) < NUM_CORES); // R3
        end
    end

endmodule

// File: rtl/tod_xfer_gate.sv
module tod_xfer_gate
    import tod_xfer_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 move_i,
    input  logic                 go_i,
    input  logic                 running_i,
    input  target_t              tgt_i,
    input  logic [NUM_CORES-1:0] ready_i,
    output logic                 accept_o,
    output logic [NUM_CORES-1:0] set_o
);

    logic [NUM_CORES-1:0] sel;
    logic                 sel_ready;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_sel
        assign sel[g] = tgt_i.valid && (tgt_i.idx == IDX_W'(g));
    end

    assign sel_ready = |(sel & ready_i);
    assign accept_o  = move_i && go_i && running_i && sel_ready;
    assign set_o     = accept_o ? sel : '0;

    always_comb begin
        AST_SET_ONEHOT: assert ($onehot0(set_o)); // R9
    end

endmodule

// File: rtl/tod_xfer_flags.sv
module tod_xfer_flags #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] set_i,
    input  logic [NUM_CORES-1:0] clr_i,
    output logic [NUM_CORES-1:0] flag_o
);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_flag
        logic flag_d;
        logic flag_q;

        always_comb begin
            flag_d = flag_q;
            if (clr_i[g]) flag_d = 1'b0;
            if (set_i[g]) flag_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= flag_d;
        end

        assign flag_o[g] = flag_q;

        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_q); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q); // R7
    end

endmodule

// File: rtl/tod_xfer_target.sv
module tod_xfer_target
    import tod_xfer_pkg::*;
#(
    parameter int          NUM_CORES    = 4,
    parameter base_tbl_t   CORE_BASE    = default_bases(),
    parameter logic [31:0] CORE_PRESENT = 32'h0000_000B,
    parameter bit          IDX_MODE_EN  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     wr_addr,
    input  logic [63:0]          wr_data,
    input  logic                 tod_running,
    input  logic [NUM_CORES-1:0] core_ready,
    input  logic [NUM_CORES-1:0] core_clr,
    output logic                 tgt_valid,
    output logic [IDX_W-1:0]     tgt_idx,
    output logic [NUM_CORES-1:0] sent,
    output logic                 err
);

    ctl_state_t           st_d;
    ctl_state_t           st_q;
    target_t              dec_tgt;
    logic                 tgt_wr;
    logic                 move_wr;
    logic                 accept;
    logic [NUM_CORES-1:0] set_vec;
    logic                 unused_bits;

    assign tgt_wr      = wr_en && (wr_addr == OFS_TARGET);
    assign move_wr     = wr_en && (wr_addr == OFS_MOVE);
    assign unused_bits = ^{wr_data[31:29], wr_data[27:0]};

    tod_xfer_decode #(
        .NUM_CORES   (NUM_CORES),
        .CORE_BASE   (CORE_BASE),
        .CORE_PRESENT(CORE_PRESENT),
        .IDX_MODE_EN (IDX_MODE_EN)
    ) u_decode (
        .addr_i     (wr_data[63:ADDR_LO]),
        .full_mode_i(wr_data[MODE_BIT]),
        .tgt_o      (dec_tgt)
    );

    tod_xfer_gate #(
        .NUM_CORES(NUM_CORES)
    ) u_gate (
        .move_i   (move_wr),
        .go_i     (wr_data[GO_BIT]),
        .running_i(tod_running),
        .tgt_i    (st_q.tgt),
        .ready_i  (core_ready),
        .accept_o (accept),
        .set_o    (set_vec)
    );

    tod_xfer_flags #(
        .NUM_CORES(NUM_CORES)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (core_clr),
        .flag_o(sent)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (tgt_wr) begin
            st_d.tgt = dec_tgt;
            st_d.err = !dec_tgt.valid;
        end else if (move_wr) begin
            st_d.err = !accept;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_valid = st_q.tgt.valid;
    assign tgt_idx   = st_q.tgt.idx;
    assign err       = st_q.err;

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_wr |=> $stable(st_q.tgt)); // R8
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(tgt_wr || move_wr)); // R4
    AST_IDX_FITTED: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (int'(tgt_idx) < NUM_CORES && CORE_PRESENT[tgt_idx])); // R3
    AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sent & ~$past(sent))); // R9
    AST_MOVE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !err); // R5

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
        AST_SENT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (sent[g] && !$past(sent[g])) |->
            $past(core_ready[g] && tod_running && tgt_valid && tgt_idx == IDX_W'(g))); // R5
    end

endmodule

// File: tb/tod_xfer_target_tb_top.sv
`timescale 1ns/1ps
module tod_xfer_target_tb_top;

    localparam int          NC      = 4;
    localparam logic [31:0] PRESENT = 32'h0000_000B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        tod_running = 1'b0;
    logic [NC-1:0] core_ready = '0;
    logic [NC-1:0] core_clr = '0;
    logic        tgt_valid;
    logic [4:0]  tgt_idx;
    logic [NC-1:0] sent;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic          exp_v = 1'b0;
    logic [4:0]    exp_idx = '0;
    logic [NC-1:0] exp_sent = '0;
    logic          exp_err = 1'b0;

    always #10 clk = ~clk;

    tod_xfer_target dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tod_running(tod_running), .core_ready(core_ready), .core_clr(core_clr),
        .tgt_valid(tgt_valid), .tgt_idx(tgt_idx), .sent(sent), .err(err)
    );

    function automatic logic [31:0] base_of(int i);
        return 32'h2000_0000 + (32'(i) << 24);
    endfunction

    function automatic logic [5:0] decode(logic [63:0] d);
        logic [31:0] a = d[63:32];
        if (d[28]) begin
            if (a[11:0] != 12'h4A3) return 6'd0;
            for (int i = 0; i < NC; i++)
                if (PRESENT[i] && base_of(i) == {a[31:12], 12'h000}) return {1'b1, 5'(i)};
            return 6'd0;
        end
        if (int'(a[4:0]) < NC && PRESENT[a[4:0]]) return {1'b1, a[4:0]};
        return 6'd0;
    endfunction

    function automatic logic [63:0] full_word(int core, logic [11:0] rnum);
        return {base_of(core) | {20'h0, rnum}, 32'h1000_0000};
    endfunction

    function automatic logic [63:0] index_word(logic [5:0] f);
        return {26'h0, f, 32'h0};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic op(logic we, logic [5:0] a, logic [63:0] d, logic run,
                      logic [NC-1:0] rdy, logic [NC-1:0] clr, string req);
        logic [NC-1:0] setv = '0;
        logic [5:0]    dec;
        wr_en = we; wr_addr = a; wr_data = d;
        tod_running = run; core_ready = rdy; core_clr = clr;
        exp_err = 1'b0;
        if (we && a == 6'h27) begin
            dec = decode(d);
            exp_v = dec[5];
            exp_idx = dec[4:0];
            exp_err = !dec[5];
        end else if (we && a == 6'h17) begin
            if (run && d[63] && exp_v && rdy[exp_idx[1:0]]) setv[exp_idx[1:0]] = 1'b1;
            else exp_err = 1'b1;
        end
        exp_sent = (exp_sent & ~clr) | setv;
        @(negedge clk);
        chk(req, "tgt_valid", 64'(tgt_valid), 64'(exp_v));
        if (exp_v) chk(req, "tgt_idx", 64'(tgt_idx), 64'(exp_idx));
        chk(req, "sent", 64'(sent), 64'(exp_sent));
        chk(req, "err", 64'(err), 64'(exp_err));
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "tgt_valid", 64'(tgt_valid), 0);
        chk("R1", "sent", 64'(sent), 0);
        chk("R1", "err", 64'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sent after release", 64'(sent), 0);

        op(1, 6'h27, index_word(6'd1), 1, 4'hF, 0, "R3");
        op(1, 6'h27, index_word(6'd2), 1, 4'hF, 0, "R4");
        op(1, 6'h27, index_word(6'b100001), 1, 4'hF, 0, "R3");
        op(1, 6'h27, index_word(6'd5), 1, 4'hF, 0, "R3");
        op(1, 6'h27, full_word(3, 12'h4A3), 1, 4'hF, 0, "R2");
        op(1, 6'h10, index_word(6'd0), 1, 4'hF, 0, "R8");
        op(0, 6'h27, index_word(6'd0), 1, 4'hF, 0, "R8");
        op(1, 6'h17, 64'h8000_0000_0000_0000, 0, 4'hF, 0, "R6");
        op(1, 6'h17, 64'h0, 1, 4'hF, 0, "R6");
        op(1, 6'h17, 64'h8000_0000_0000_0000, 1, 4'h7, 0, "R6");
        op(1, 6'h17, 64'h8000_0000_0000_0000, 1, 4'h8, 0, "R5");
        op(0, 6'h00, 64'h0, 1, 4'h0, 0, "R7");
        op(0, 6'h00, 64'h0, 1, 4'h0, 4'h8, "R7");
        op(1, 6'h27, full_word(0, 12'h4A3), 1, 4'hF, 0, "R2");
        op(1, 6'h17, 64'h8000_0000_0000_0000, 1, 4'h1, 4'h1, "R7");
        op(1, 6'h27, full_word(1, 12'h4A2), 1, 4'hF, 0, "R2");
        op(1, 6'h17, 64'h8000_0000_0000_0000, 1, 4'hF, 0, "R6");
        op(1, 6'h27, full_word(2, 12'h4A3), 1, 4'hF, 0, "R2");
        op(1, 6'h27, full_word(9, 12'h4A3), 1, 4'hF, 0, "R2");

        for (int n = 0; n < 400; n++) begin
            int k = int'($urandom % 6);
            logic [63:0]   d;
            logic [5:0]    a;
            logic [NC-1:0] clr = '0;
            for (int b = 0; b < NC; b++) clr[b] = (($urandom % 8) == 0);
            case (k)
                0: begin a = 6'h27; d = full_word(int'($urandom % 6), ($urandom % 3 == 0) ? 12'h4A0 : 12'h4A3); end
                1: begin a = 6'h27; d = index_word(6'($urandom)); end
                2: begin a = 6'h27; d = {$urandom, $urandom}; end
                3, 4: begin a = 6'h17; d = {($urandom % 5 != 0), 63'($urandom)}; end
                default: begin
                    a = 6'($urandom);
                    if (a == 6'h27 || a == 6'h17) a = 6'h3F;
                    d = {$urandom, $urandom};
                end
            endcase
            op(1, a, d, ($urandom % 4 != 0), 4'($urandom), clr, "R9");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule